// File: doc/BRIEF.md
# Top-of-Stack Register Cache with Memory Spill

This block is the operand stack of a zero-operand processor. The two most recent entries sit in a pair of registers, one on top and one under it. Each register has its own valid bit. Entries deeper than those two go into a single-ported, word-addressed memory. A stack pointer indexes that memory, starts at zero and counts upward. A client issues push, pop or reduce requests. A reduce folds the two top entries into one word, and an external ALU supplies that word from the two register outputs.

The memory is used only when the register pair cannot hold the entries on its own. A push onto a full register pair first writes the lower register to memory. A pop or reduce that empties the lower register while memory still holds entries brings one word back from memory. That refill costs one stall cycle. The block reports the total entry count. A push that would move the pointer past a configured limit is refused with an overflow pulse. A pop or reduce that lacks operands is refused with an underflow pulse.

Top module: `tos_cache_stack`

## Requirements
- R1: The request code is 2'b00 push, 2'b01 pop, 2'b10 reduce and 2'b11 idle. An accepted push shows the new word on `topA` one cycle later. If the top register was valid, its old word moves to `topB`.
- R2: Entries stay in the registers while at most two are held. A push onto two valid registers writes the lower word to memory and increments the pointer. A later refill returns that word unchanged.
- R3: A pop moves `topB` into `topA`. If memory holds entries, `ready` is low for exactly one cycle. After that cycle `topB` holds the most recently spilled word and the pointer has decremented.
- R4: A reduce replaces the top two entries with `aluResult`, sampled at the accepting edge. It refills the lower register under the same rule as R3.
- R5: A push while both registers are valid and the pointer equals `SP_LIMIT` raises `overflow` for one cycle. It changes no entry, valid bit or depth.
- R6: A pop on an empty stack, or a reduce with fewer than two entries, raises `underflow` for one cycle and changes nothing.
- R7: The memory sees at most one spill or one fill per cycle. A request presented while `ready` is low has no effect.
- R8: After reset the stack is empty: depth 0, both valid bits low, `ready` high and both flags low.
- R9: `depth` equals the number of entries held: the pointer plus the two valid bits. `validB` is never set without `validA`.
- R10: Words leave the stack in the reverse of the order they entered, including words that passed through memory.
- R11: The idle code (2'b11) changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe, taken when `ready` is high |
| reqOp | input | 2 | Request code (see R1) |
| pushData | input | DATA_W | Word to push |
| aluResult | input | DATA_W | Result of the external ALU for a reduce |
| ready | output | 1 | Low during a refill cycle |
| topA | output | DATA_W | Top entry |
| topB | output | DATA_W | Second entry |
| validA | output | 1 | `topA` holds data |
| validB | output | 1 | `topB` holds data |
| depth | output | ADDR_W | Total entries held |
| overflow | output | 1 | One-cycle pulse: push refused at the limit |
| underflow | output | 1 | One-cycle pulse: pop or reduce lacked operands |

## Verification
The bench builds the block with a four-word memory and `SP_LIMIT` of 4, so the stack holds six entries at most. With that size, a short vector table reaches every boundary: the step from register-only to spilling, a full stack refused with overflow, and the chain of refills that drains memory back to the registers. The external ALU is modelled as the sum of `topA` and `topB`. The reduce results can therefore be computed by hand.

// File: rtl/tos_stack_pkg.sv
package tos_stack_pkg;

  typedef enum logic [1:0] {
    OP_PUSH   = 2'b00,
    OP_POP    = 2'b01,
    OP_REDUCE = 2'b10,
    OP_NONE   = 2'b11
  } stackOp_e;

  typedef enum logic [1:0] {
    A_HOLD   = 2'b00,
    A_PUSH   = 2'b01,
    A_ALU    = 2'b10,
    A_FROM_B = 2'b11
  } aSrc_e;

  typedef enum logic [1:0] {
    B_HOLD     = 2'b00,
    B_FROM_A   = 2'b01,
    B_FROM_MEM = 2'b10,
    B_CLEAR    = 2'b11
  } bSrc_e;

  typedef struct packed {
    aSrc_e aSrc;
    bSrc_e bSrc;
    logic  spill;
    logic  fill;
    logic  ovf;
    logic  unf;
  } ctrlStrobe_t;

endpackage

// File: rtl/tos_stack_ctrl.sv
module tos_stack_ctrl
  import tos_stack_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic [1:0]  reqOp,
  input  logic        validA,
  input  logic        validB,
  input  logic        memEmpty,
  input  logic        memFull,
  output logic        ready,
  output ctrlStrobe_t ctl
);

  typedef enum logic {ST_IDLE, ST_FILL} state_e;

  state_e state;
  logic   goFill;

  always_comb begin
    ctl    = '0;
    goFill = 1'b0;
    if (state == ST_FILL) begin
      // The only memory access this cycle is the refill; any request is ignored.
      ctl.fill = 1'b1;
      ctl.bSrc = B_FROM_MEM;
    end else if (reqValid) begin
      case (reqOp)
        OP_PUSH: begin
          if (validA && validB && memFull) begin
            ctl.ovf = 1'b1;
          end else begin
            ctl.aSrc = A_PUSH;
            if (validA) ctl.bSrc = B_FROM_A;
            if (validA && validB) ctl.spill = 1'b1;
          end
        end
        OP_POP: begin
          if (!validA) begin
            ctl.unf = 1'b1;
          end else begin
            ctl.aSrc = A_FROM_B;
            ctl.bSrc = B_CLEAR;
            goFill   = !memEmpty;
          end
        end
        OP_REDUCE: begin
          if (!(validA && validB)) begin
            ctl.unf = 1'b1;
          end else begin
            ctl.aSrc = A_ALU;
            ctl.bSrc = B_CLEAR;
            goFill   = !memEmpty;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= goFill ? ST_FILL : ST_IDLE;
  end

  assign ready = (state == ST_IDLE);

  // A refill stall lasts one cycle only.
  assert_stall_one_cycle_R3: assert property (@(posedge clk) disable iff (!rstN)
    !ready |=> ready);

  // A refused request never also moves data.
  assert_refusal_moves_nothing_R6: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.ovf || ctl.unf) |-> (ctl.aSrc == A_HOLD && !ctl.spill));

endmodule

// File: rtl/tos_stack_datapath.sv
module tos_stack_datapath
  import tos_stack_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 32,
  parameter int MEM_DEPTH = 64,
  parameter int SP_LIMIT  = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       ctl,
  input  logic [DATA_W-1:0] pushData,
  input  logic [DATA_W-1:0] aluResult,
  output logic [DATA_W-1:0] regA,
  output logic [DATA_W-1:0] regB,
  output logic              validA,
  output logic              validB,
  output logic [ADDR_W-1:0] sp,
  output logic              memEmpty,
  output logic              memFull,
  output logic              overflow,
  output logic              underflow
);

  localparam int IDX_W = (MEM_DEPTH > 1) ? $clog2(MEM_DEPTH) : 1;

  logic [DATA_W-1:0] mem [MEM_DEPTH];
  logic [IDX_W-1:0]  spIdx;
  logic [IDX_W-1:0]  spDecIdx;
  logic [DATA_W-1:0] fillWord;

  assign spIdx    = sp[IDX_W-1:0];
  assign spDecIdx = spIdx - IDX_W'(1);
  assign fillWord = mem[spDecIdx];
  assign memEmpty = (sp == '0);
  assign memFull  = (sp >= ADDR_W'(SP_LIMIT));

  // Spill port: the only memory write.
  always_ff @(posedge clk) begin
    if (ctl.spill) mem[spIdx] <= regB;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      regA      <= '0;
      regB      <= '0;
      validA    <= 1'b0;
      validB    <= 1'b0;
      sp        <= '0;
      overflow  <= 1'b0;
      underflow <= 1'b0;
    end else begin
      overflow  <= ctl.ovf;
      underflow <= ctl.unf;
      case (ctl.aSrc)
        A_PUSH:   begin regA <= pushData;  validA <= 1'b1;   end
        A_ALU:    begin regA <= aluResult; validA <= 1'b1;   end
        A_FROM_B: begin regA <= regB;      validA <= validB; end
        default: ;
      endcase
      case (ctl.bSrc)
        B_FROM_A:   begin regB <= regA;     validB <= validA; end
        B_FROM_MEM: begin regB <= fillWord; validB <= 1'b1;   end
        B_CLEAR:    validB <= 1'b0;
        default: ;
      endcase
      if (ctl.spill)     sp <= sp + ADDR_W'(1);
      else if (ctl.fill) sp <= sp - ADDR_W'(1);
    end
  end

  assert_spill_needs_full_regs_R2: assert property (@(posedge clk) disable iff (!rstN)
    ctl.spill |-> (validA && validB));

  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rstN)
    ctl.spill |-> (sp < ADDR_W'(SP_LIMIT)));

  assert_refill_when_b_empty_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!memEmpty && !validB) |-> ctl.fill);

  assert_fill_holds_top_R7: assert property (@(posedge clk) disable iff (!rstN)
    ctl.fill |=> $stable(regA));

  assert_underflow_keeps_state_R6: assert property (@(posedge clk) disable iff (!rstN)
    ctl.unf |=> ($stable(sp) && $stable(validA) && $stable(validB)));

  assert_b_implies_a_R9: assert property (@(posedge clk) disable iff (!rstN)
    validB |-> validA);

endmodule

// File: rtl/tos_cache_stack.sv
module tos_cache_stack
  import tos_stack_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 32,
  parameter int MEM_DEPTH = 64,
  parameter int SP_LIMIT  = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [1:0]        reqOp,
  input  logic [DATA_W-1:0] pushData,
  input  logic [DATA_W-1:0] aluResult,
  output logic              ready,
  output logic [DATA_W-1:0] topA,
  output logic [DATA_W-1:0] topB,
  output logic              validA,
  output logic              validB,
  output logic [ADDR_W-1:0] depth,
  output logic              overflow,
  output logic              underflow
);

  ctrlStrobe_t       ctl;
  logic              memEmpty;
  logic              memFull;
  logic [ADDR_W-1:0] sp;

  tos_stack_ctrl i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqOp    (reqOp),
    .validA   (validA),
    .validB   (validB),
    .memEmpty (memEmpty),
    .memFull  (memFull),
    .ready    (ready),
    .ctl      (ctl)
  );

  tos_stack_datapath #(
    .DATA_W    (DATA_W),
    .ADDR_W    (ADDR_W),
    .MEM_DEPTH (MEM_DEPTH),
    .SP_LIMIT  (SP_LIMIT)
  ) i_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .pushData  (pushData),
    .aluResult (aluResult),
    .regA      (topA),
    .regB      (topB),
    .validA    (validA),
    .validB    (validB),
    .sp        (sp),
    .memEmpty  (memEmpty),
    .memFull   (memFull),
    .overflow  (overflow),
    .underflow (underflow)
  );

  assign depth = sp + ADDR_W'(validA) + ADDR_W'(validB);

endmodule

// File: tb/test_tos_cache_stack.sv
module test_tos_cache_stack;
  import tos_stack_pkg::*;

  localparam int DATA_W = 32;
  localparam int ADDR_W = 32;

  typedef struct packed {
    logic [1:0]  op;
    logic [31:0] data;
    logic [31:0] expA;
    logic [31:0] expB;
    logic        expVA;
    logic        expVB;
    logic [31:0] expDepth;
    logic        expOvf;
    logic        expUnf;
    logic        expStall;
  } vec_t;

  function automatic vec_t mk(logic [1:0] op, logic [31:0] d, logic [31:0] a, logic [31:0] b,
                              logic va, logic vb, logic [31:0] dep,
                              logic ov, logic un, logic st);
    vec_t v;
    v = '{op, d, a, b, va, vb, dep, ov, un, st};
    return v;
  endfunction

  localparam int NVEC = 23;
  localparam vec_t VEC [NVEC] = '{
    mk(2'b00, 10, 10,  0, 1, 0, 1, 0, 0, 0),
    mk(2'b00, 20, 20, 10, 1, 1, 2, 0, 0, 0),
    mk(2'b00, 30, 30, 20, 1, 1, 3, 0, 0, 0),
    mk(2'b00, 40, 40, 30, 1, 1, 4, 0, 0, 0),
    mk(2'b10,  0, 70, 20, 1, 1, 3, 0, 0, 1),
    mk(2'b01,  0, 20, 10, 1, 1, 2, 0, 0, 1),
    mk(2'b01,  0, 10,  0, 1, 0, 1, 0, 0, 0),
    mk(2'b10,  0, 10,  0, 1, 0, 1, 0, 1, 0),
    mk(2'b01,  0,  0,  0, 0, 0, 0, 0, 0, 0),
    mk(2'b01,  0,  0,  0, 0, 0, 0, 0, 1, 0),
    mk(2'b11,  0,  0,  0, 0, 0, 0, 0, 0, 0),
    mk(2'b00,  1,  1,  0, 1, 0, 1, 0, 0, 0),
    mk(2'b00,  2,  2,  1, 1, 1, 2, 0, 0, 0),
    mk(2'b00,  3,  3,  2, 1, 1, 3, 0, 0, 0),
    mk(2'b00,  4,  4,  3, 1, 1, 4, 0, 0, 0),
    mk(2'b00,  5,  5,  4, 1, 1, 5, 0, 0, 0),
    mk(2'b00,  6,  6,  5, 1, 1, 6, 0, 0, 0),
    mk(2'b00,  7,  6,  5, 1, 1, 6, 1, 0, 0),
    mk(2'b01,  0,  5,  4, 1, 1, 5, 0, 0, 1),
    mk(2'b01,  0,  4,  3, 1, 1, 4, 0, 0, 1),
    mk(2'b01,  0,  3,  2, 1, 1, 3, 0, 0, 1),
    mk(2'b01,  0,  2,  1, 1, 1, 2, 0, 0, 1),
    mk(2'b01,  0,  1,  0, 1, 0, 1, 0, 0, 0)
  };

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              reqValid = 1'b0;
  logic [1:0]        reqOp = 2'b11;
  logic [DATA_W-1:0] pushData = '0;
  logic [DATA_W-1:0] aluResult;
  logic              ready;
  logic [DATA_W-1:0] topA;
  logic [DATA_W-1:0] topB;
  logic              validA;
  logic              validB;
  logic [ADDR_W-1:0] depth;
  logic              overflow;
  logic              underflow;

  int  nChecks = 0;
  int  nFails  = 0;
  bit  done    = 1'b0;

  always #2.5 clk = ~clk;

  // External ALU model: sum of the two top entries.
  assign aluResult = topA + topB;

  tos_cache_stack #(
    .DATA_W    (DATA_W),
    .ADDR_W    (ADDR_W),
    .MEM_DEPTH (4),
    .SP_LIMIT  (4)
  ) i_tos_cache_stack (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .reqOp     (reqOp),
    .pushData  (pushData),
    .aluResult (aluResult),
    .ready     (ready),
    .topA      (topA),
    .topB      (topB),
    .validA    (validA),
    .validB    (validB),
    .depth     (depth),
    .overflow  (overflow),
    .underflow (underflow)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic runOp(input logic [1:0] op, input logic [31:0] d,
                       output bit stall, output bit ovf, output bit unf);
    @(negedge clk);
    reqValid = 1'b1;
    reqOp    = op;
    pushData = d;
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    reqOp    = 2'b11;
    ovf   = overflow;
    unf   = underflow;
    stall = !ready;
    if (stall) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic checkIdle(input string req);
    check(depth == 0, req, "depth", depth, 0);
    check(!validA && !validB, req, "valid bits", {validA, validB}, 0);
    check(ready, req, "ready", ready, 1);
    check(!overflow && !underflow, req, "flags", {overflow, underflow}, 0);
  endtask

  initial begin
    bit st, ov, un;
    string tag;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    checkIdle("R8");

    foreach (VEC[i]) begin
      runOp(VEC[i].op, VEC[i].data, st, ov, un);
      case (VEC[i].op)
        2'b00:   tag = "R1";
        2'b01:   tag = "R3/R10";
        2'b10:   tag = "R4";
        default: tag = "R11";
      endcase
      check(validA == VEC[i].expVA, tag, "validA", validA, VEC[i].expVA);
      check(validB == VEC[i].expVB, tag, "validB", validB, VEC[i].expVB);
      if (VEC[i].expVA) check(topA == VEC[i].expA, tag, "topA", topA, VEC[i].expA);
      if (VEC[i].expVB) check(topB == VEC[i].expB, "R2", "topB", topB, VEC[i].expB);
      check(depth == VEC[i].expDepth, "R9", "depth", depth, VEC[i].expDepth);
      check(ov == VEC[i].expOvf, "R5", "overflow", ov, VEC[i].expOvf);
      check(un == VEC[i].expUnf, "R6", "underflow", un, VEC[i].expUnf);
      check(st == VEC[i].expStall, "R3", "stall", st, VEC[i].expStall);
    end

    // R7: a push presented during the refill cycle is ignored.
    runOp(2'b00, 7, st, ov, un);
    runOp(2'b00, 8, st, ov, un);
    runOp(2'b00, 9, st, ov, un);
    check(depth == 4, "R2", "depth before stall test", depth, 4);
    @(negedge clk);
    reqValid = 1'b1;
    reqOp    = 2'b01;
    @(posedge clk);
    @(negedge clk);
    check(!ready, "R7", "ready in refill", ready, 0);
    reqOp    = 2'b00;
    pushData = 99;
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    reqOp    = 2'b11;
    check(ready, "R7", "ready after refill", ready, 1);
    check(topA == 8, "R7", "topA after ignored push", topA, 8);
    check(topB == 7, "R7", "topB after ignored push", topB, 7);
    check(depth == 3, "R7", "depth after ignored push", depth, 3);

    // R8: reset in the middle of use empties the stack.
    @(negedge clk);
    rstN = 1'b0;
    @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    checkIdle("R8");

    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

endmodule